// File: doc/BRIEF.md
# UART Receive Status Flag Controller

This block keeps the receive-side flags of a UART. It sits between the receive shift logic and a one-word holding register. The shift logic reports each finished word as a one-cycle pulse. With the pulse come the word and its parity, framing, noise and break indications. The block decides whether the word moves into the holding register or is dropped as an overrun. It then latches the matching error flags and drives an interrupt request.

Software clears the flags by reading the status register and then accessing the data register. A single sequence latch arms on the status read. The clear takes effect only on the data access that comes straight after it. Data reads and clears the overrun, noise and framing flags. Data reads and data writes both clear the parity flag. When an overrun happens, the word already held is kept and the error indications of the dropped word are ignored.

Top module: `uart_rx_flag_ctrl`

## Requirements
- R1: After reset all flags, the status value, the held word and the interrupt request are zero.
- R2: A completion pulse while data-ready is clear copies the word into the holding register and sets data-ready, both visible after the next clock edge.
- R3: A data register read clears data-ready after the clock edge. The held word stays readable.
- R4: A completion pulse while data-ready is set sets the overrun flag. The held word is kept and the new word is dropped.
- R5: Overrun, noise and framing clear only on a data read whose previous register access was a status read. A data write in that position leaves them set.
- R6: Parity clears on a data read or a data write whose previous register access was a status read.
- R7: Any other access between the status read and the data access cancels the clear. So do another-register access, a data access without a preceding status read, or a second data access.
- R8: A transferred word sets framing on its framing or break indication, noise on its noise indication and parity on its parity indication. The status value carries parity at bit 0, framing at bit 1, noise at bit 2, overrun at bit 3 and data-ready at bit 5. Bits 4, 6 and 7 read zero.
- R9: A dropped word sets only overrun, even if it carries framing, break, noise or parity indications.
- R10: While the one-bit-sampling input is high, a transferred word's noise indication does not set the noise flag.
- R11: The interrupt is (rx_irq_en AND (data-ready OR overrun)) OR (par_irq_en AND parity). Noise and framing never raise it alone.
- R12: A flag set and cleared in the same cycle stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| word_done | input | 1 | One-cycle pulse: shift logic has a finished word |
| word_data | input | DATA_W | Finished word |
| word_par_err | input | 1 | Parity error on the finished word |
| word_frm_err | input | 1 | Framing error (loss of sync or excess noise) on the finished word |
| word_brk | input | 1 | Break character detected on the finished word |
| word_noise | input | 1 | Noise seen on the finished word |
| one_bit_smp | input | 1 | One-bit sampling mode, suppresses the noise flag |
| rx_irq_en | input | 1 | Interrupt enable for data-ready and overrun |
| par_irq_en | input | 1 | Interrupt enable for parity |
| stat_rd | input | 1 | Status register read strobe |
| data_rd | input | 1 | Data register read strobe |
| data_wr | input | 1 | Data register write strobe |
| other_acc | input | 1 | Access strobe for any other register |
| status | output | 8 | Status register value |
| rx_data | output | DATA_W | Held received word |
| data_ready | output | 1 | Holding register full |
| ovr_flag | output | 1 | Overrun flag |
| noise_flag | output | 1 | Noise flag |
| frm_flag | output | 1 | Framing flag |
| par_flag | output | 1 | Parity flag |
| irq | output | 1 | Interrupt request |

## Verification
Every flag and the held word are registered. A strobe or completion pulse applied before a clock edge shows up on the outputs just after that edge, one cycle later. The interrupt and the status value are combinational from those registers, so they change in the same cycle as the flags. The bench drives each strobe for one cycle starting at a falling edge. It samples at the next falling edge, half a period after the rising edge that took the stimulus. This way each check sees exactly one update. The clear-sequence and same-cycle set/clear cases are built by placing strobes on consecutive cycles or on the same cycle.

// File: rtl/uart_rxf_pkg.sv
package uart_rxf_pkg;

    localparam int STAT_W   = 8;
    localparam int ST_PAR   = 0;
    localparam int ST_FRM   = 1;
    localparam int ST_NOISE = 2;
    localparam int ST_OVR   = 3;
    localparam int ST_RDY   = 5;

    typedef struct packed {
        logic ovr;
        logic noise;
        logic frm;
        logic par;
    } err_flags_t;

endpackage

// File: rtl/rxf_clr_seq.sv
module rxf_clr_seq (
    input  logic clk,
    input  logic rst_n,
    input  logic stat_rd,
    input  logic data_rd,
    input  logic data_wr,
    input  logic other_acc,
    output logic clr_on_rd,
    output logic clr_on_any
);

    typedef struct packed {
        logic armed;
    } seq_st_t;

    seq_st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (stat_rd) begin
            s_d.armed = 1'b1;
        end else if (data_rd || data_wr || other_acc) begin
            s_d.armed = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign clr_on_rd  = s_q.armed && data_rd && !stat_rd;
    assign clr_on_any = s_q.armed && (data_rd || data_wr) && !stat_rd;

    // R7
    seq_disarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((data_rd || data_wr || other_acc) && !stat_rd) |=> !s_q.armed);

endmodule

// File: rtl/rxf_hold_reg.sv
module rxf_hold_reg #(
    parameter int DATA_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              word_done,
    input  logic [DATA_W-1:0] word_data,
    input  logic              data_rd,
    output logic              xfer,
    output logic              ovr_evt,
    output logic              rdy,
    output logic [DATA_W-1:0] held
);

    typedef struct packed {
        logic              rdy;
        logic [DATA_W-1:0] word;
    } hold_st_t;

    hold_st_t h_d, h_q;

    always_comb begin
        h_d     = h_q;
        xfer    = word_done && !h_q.rdy;
        ovr_evt = word_done &&  h_q.rdy;
        if (data_rd) begin
            h_d.rdy = 1'b0;
        end
        if (xfer) begin
            h_d.rdy  = 1'b1;
            h_d.word = word_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            h_q <= '0;
        end else begin
            h_q <= h_d;
        end
    end

    assign rdy  = h_q.rdy;
    assign held = h_q.word;

    // R4
    ovr_keeps_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (word_done && rdy) |=> $stable(held));

    // R2
    xfer_loads_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (word_done && !rdy) |=> (rdy && held == $past(word_data)));

endmodule

// File: rtl/rxf_err_flags.sv
module rxf_err_flags
    import uart_rxf_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       xfer,
    input  logic       ovr_evt,
    input  logic       word_par_err,
    input  logic       word_frm_err,
    input  logic       word_brk,
    input  logic       word_noise,
    input  logic       one_bit_smp,
    input  logic       clr_on_rd,
    input  logic       clr_on_any,
    output err_flags_t flags
);

    err_flags_t f_d, f_q;
    err_flags_t set_v;

    always_comb begin
        set_v       = '0;
        set_v.ovr   = ovr_evt;
        set_v.noise = xfer && word_noise && !one_bit_smp;
        set_v.frm   = xfer && (word_frm_err || word_brk);
        set_v.par   = xfer && word_par_err;

        f_d = f_q;
        if (clr_on_rd) begin
            f_d.ovr   = 1'b0;
            f_d.noise = 1'b0;
            f_d.frm   = 1'b0;
        end
        if (clr_on_any) begin
            f_d.par = 1'b0;
        end
        f_d = f_d | set_v;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            f_q <= '0;
        end else begin
            f_q <= f_d;
        end
    end

    assign flags = f_q;

    // R4
    ovr_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_evt |=> flags.ovr);

    // R9
    drop_no_frm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_evt && !clr_on_rd) |=> $stable(flags.frm) && $stable(flags.noise));

    // R10
    one_bit_nf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (one_bit_smp && !flags.noise) |=> !flags.noise);

    // R5
    ovr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flags.ovr && !clr_on_rd) |=> flags.ovr);

    // R6
    par_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flags.par && !clr_on_any) |=> flags.par);

endmodule

// File: rtl/uart_rx_flag_ctrl.sv
module uart_rx_flag_ctrl
    import uart_rxf_pkg::*;
#(
    parameter int DATA_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              word_done,
    input  logic [DATA_W-1:0] word_data,
    input  logic              word_par_err,
    input  logic              word_frm_err,
    input  logic              word_brk,
    input  logic              word_noise,
    input  logic              one_bit_smp,
    input  logic              rx_irq_en,
    input  logic              par_irq_en,
    input  logic              stat_rd,
    input  logic              data_rd,
    input  logic              data_wr,
    input  logic              other_acc,
    output logic [STAT_W-1:0] status,
    output logic [DATA_W-1:0] rx_data,
    output logic              data_ready,
    output logic              ovr_flag,
    output logic              noise_flag,
    output logic              frm_flag,
    output logic              par_flag,
    output logic              irq
);

    logic       clr_on_rd, clr_on_any;
    logic       xfer, ovr_evt, rdy;
    err_flags_t flags;

    rxf_clr_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .stat_rd    (stat_rd),
        .data_rd    (data_rd),
        .data_wr    (data_wr),
        .other_acc  (other_acc),
        .clr_on_rd  (clr_on_rd),
        .clr_on_any (clr_on_any)
    );

    rxf_hold_reg #(.DATA_W(DATA_W)) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .word_done (word_done),
        .word_data (word_data),
        .data_rd   (data_rd),
        .xfer      (xfer),
        .ovr_evt   (ovr_evt),
        .rdy       (rdy),
        .held      (rx_data)
    );

    rxf_err_flags u_err (
        .clk          (clk),
        .rst_n        (rst_n),
        .xfer         (xfer),
        .ovr_evt      (ovr_evt),
        .word_par_err (word_par_err),
        .word_frm_err (word_frm_err),
        .word_brk     (word_brk),
        .word_noise   (word_noise),
        .one_bit_smp  (one_bit_smp),
        .clr_on_rd    (clr_on_rd),
        .clr_on_any   (clr_on_any),
        .flags        (flags)
    );

    always_comb begin
        status           = '0;
        status[ST_PAR]   = flags.par;
        status[ST_FRM]   = flags.frm;
        status[ST_NOISE] = flags.noise;
        status[ST_OVR]   = flags.ovr;
        status[ST_RDY]   = rdy;
    end

    assign data_ready = rdy;
    assign ovr_flag   = flags.ovr;
    assign noise_flag = flags.noise;
    assign frm_flag   = flags.frm;
    assign par_flag   = flags.par;
    assign irq        = (rx_irq_en && (rdy || flags.ovr)) || (par_irq_en && flags.par);

    // R11
    irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rdy && !flags.ovr && !flags.par) |-> !irq);

    // R3
    rd_clears_rdy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (data_rd && !word_done) |=> !data_ready);

endmodule

// File: tb/sim_uart_rx_flag_ctrl.sv
`timescale 1ns/1ps
module sim_uart_rx_flag_ctrl;

    localparam int DW = 9;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          word_done = 0, word_par_err = 0, word_frm_err = 0, word_brk = 0, word_noise = 0;
    logic [DW-1:0] word_data = '0;
    logic          one_bit_smp = 0, rx_irq_en = 0, par_irq_en = 0;
    logic          stat_rd = 0, data_rd = 0, data_wr = 0, other_acc = 0;
    logic [7:0]    status;
    logic [DW-1:0] rx_data;
    logic          data_ready, ovr_flag, noise_flag, frm_flag, par_flag, irq;

    int vecs = 0;
    int errs = 0;

    always #2 clk = ~clk;

    uart_rx_flag_ctrl #(.DATA_W(DW)) u0 (
        .clk(clk), .rst_n(rst_n), .word_done(word_done), .word_data(word_data),
        .word_par_err(word_par_err), .word_frm_err(word_frm_err), .word_brk(word_brk),
        .word_noise(word_noise), .one_bit_smp(one_bit_smp), .rx_irq_en(rx_irq_en),
        .par_irq_en(par_irq_en), .stat_rd(stat_rd), .data_rd(data_rd), .data_wr(data_wr),
        .other_acc(other_acc), .status(status), .rx_data(rx_data), .data_ready(data_ready),
        .ovr_flag(ovr_flag), .noise_flag(noise_flag), .frm_flag(frm_flag),
        .par_flag(par_flag), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vecs++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] st(input logic rdy, ovr, nf, fe, pe);
        return {2'b00, rdy, 1'b0, ovr, nf, fe, pe};
    endfunction

    task automatic tick();
        @(negedge clk);
        word_done = 0; word_par_err = 0; word_frm_err = 0; word_brk = 0; word_noise = 0;
        stat_rd = 0; data_rd = 0; data_wr = 0; other_acc = 0;
    endtask

    task automatic recv(input logic [DW-1:0] w, input logic pe, fe, brk, nf);
        word_done = 1; word_data = w; word_par_err = pe; word_frm_err = fe;
        word_brk = brk; word_noise = nf;
        tick();
    endtask

    task automatic srd(); stat_rd = 1; tick(); endtask
    task automatic drd(); data_rd = 1; tick(); endtask
    task automatic dwr(); data_wr = 1; tick(); endtask

    task automatic do_reset();
        rst_n = 0;
        tick(); tick();
        rst_n = 1;
        tick();
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 status", status, 0);
        chk("R1 data", rx_data, 0);
        chk("R1 irq", irq, 0);
    endtask

    task automatic t_basic();
        do_reset();
        recv(9'h0A5, 0, 0, 0, 0);
        chk("R2 data", rx_data, 9'h0A5);
        chk("R2 ready", status, st(1, 0, 0, 0, 0));
        drd();
        chk("R3 ready clr", data_ready, 0);
        chk("R3 data kept", rx_data, 9'h0A5);
        recv(9'h13C, 0, 0, 0, 0);
        chk("R2 second word", rx_data, 9'h13C);
    endtask

    task automatic t_overrun();
        do_reset();
        recv(9'h011, 0, 0, 0, 0);
        recv(9'h122, 1, 1, 1, 1);
        chk("R4 ovr set", ovr_flag, 1);
        chk("R4 word kept", rx_data, 9'h011);
        chk("R9 only ovr", status, st(1, 1, 0, 0, 0));
    endtask

    task automatic t_err_bits();
        do_reset();
        recv(9'h001, 1, 0, 0, 0);
        chk("R8 par bit0", status, st(1, 0, 0, 0, 1));
        do_reset();
        recv(9'h002, 0, 1, 0, 0);
        chk("R8 frm bit1", status, st(1, 0, 0, 1, 0));
        do_reset();
        recv(9'h003, 0, 0, 1, 0);
        chk("R8 brk frm", frm_flag, 1);
        do_reset();
        recv(9'h004, 0, 0, 0, 1);
        chk("R8 noise bit2", status, st(1, 0, 1, 0, 0));
    endtask

    task automatic t_one_bit();
        do_reset();
        one_bit_smp = 1;
        recv(9'h055, 0, 0, 0, 1);
        chk("R10 noise suppressed", noise_flag, 0);
        one_bit_smp = 0;
    endtask

    task automatic t_clear_seq();
        do_reset();
        recv(9'h031, 0, 0, 0, 1);
        recv(9'h032, 0, 0, 0, 0);
        drd();
        recv(9'h033, 1, 1, 0, 0);
        chk("R8 all set", status, st(1, 1, 1, 1, 1));
        srd(); dwr();
        chk("R5 write keeps", status, st(1, 1, 1, 1, 0));
        chk("R6 write clears par", par_flag, 0);
        drd();
        chk("R7 no stat read", status, st(0, 1, 1, 1, 0));
        srd(); other_acc = 1; tick(); drd();
        chk("R7 other access", status, st(0, 1, 1, 1, 0));
        srd(); tick(); drd();
        chk("R5 idle gap keeps clear", status, st(0, 0, 0, 0, 0));
    endtask

    task automatic t_par_read();
        do_reset();
        recv(9'h0F0, 1, 0, 0, 0);
        srd(); drd();
        chk("R6 read clears par", status, st(0, 0, 0, 0, 0));
        recv(9'h0F1, 1, 0, 0, 0);
        srd(); drd(); drd();
        chk("R7 second data acc", status, 0);
    endtask

    task automatic t_irq();
        do_reset();
        rx_irq_en = 0; par_irq_en = 0;
        recv(9'h077, 1, 1, 0, 1);
        chk("R11 disabled", irq, 0);
        par_irq_en = 1; #0.1;
        chk("R11 par irq", irq, 1);
        par_irq_en = 0; rx_irq_en = 1; #0.1;
        chk("R11 rdy irq", irq, 1);
        drd(); #0.1;
        chk("R11 nf fe silent", irq, 0);
        recv(9'h078, 0, 0, 0, 0);
        recv(9'h079, 0, 0, 0, 0);
        drd(); #0.1;
        chk("R11 ovr irq", irq, 1);
        rx_irq_en = 0;
    endtask

    task automatic t_set_wins();
        do_reset();
        recv(9'h101, 0, 0, 0, 0);
        recv(9'h102, 0, 0, 0, 0);
        srd();
        data_rd = 1; word_done = 1; word_data = 9'h103;
        tick();
        chk("R12 ovr stays", ovr_flag, 1);
        chk("R12 ready cleared", data_ready, 0);
        chk("R12 word kept", rx_data, 9'h101);
        srd(); drd();
        chk("R5 later clear", ovr_flag, 0);
    endtask

    initial begin
        #200000;
        errs++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end

    initial begin
        t_reset();
        t_basic();
        t_overrun();
        t_err_bits();
        t_one_bit();
        t_clear_seq();
        t_par_read();
        t_irq();
        t_set_wins();
        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end

endmodule